// File: doc/BRIEF.md
# HDB3 Receive Decoder with Violation Alarm

This block sits after the line receiver's slicer and clock recovery. Each cycle of the recovered receive clock it takes one positive-rail bit and one negative-rail bit. In single-rail operation it merges the two rails into unipolar NRZ data. When HDB3 is enabled it removes zero-substitution codes. Its second output carries a one-cycle alarm for line code errors.

In dual-rail operation the two rails pass straight through. The second output then carries the negative rail, and an alternate-polarity setting presents both rails active-low.

Two overrides act at the output stage. A receive AIS request replaces the data sent toward the terminal with all marks. An active-low alarm-test input drives the alarm high without touching the data.

Substitution removal needs a bit slot that arrives three bits before the violating mark. All rail data therefore passes through a three-stage line and then the output register. That gives a fixed data latency in every mode.

Top module: `hdb3_rx_decoder`

## Requirements
- R1: While reset is high, and in the first cycle after it, both outputs are 0.
- R2: In single-rail mode a mark on either rail (line_p or line_n high) gives a 1 on rx_data_or_p, and a slot with no mark gives a 0. A rail bit sampled at clock edge k shows on the data output after edge k+3 and holds for one full cycle.
- R3: In single-rail mode with hdb3_en low, a mark with the same polarity as the previous mark is a bipolar violation. It sets rx_alarm_or_n in the cycle after the edge that samples it. The marks themselves still decode as 1s. A positive mark is line_p high, and a simultaneous line_p and line_n counts as positive.
- R4: In single-rail mode with hdb3_en high, a valid substitution mark is one that repeats the polarity of the last mark and is opposite in polarity to the last valid substitution mark. Such a mark is decoded as 0, the three bit slots before it are also decoded as 0, and no alarm is raised.
- R5: With hdb3_en high, a repeated-polarity mark that has the same polarity as the last valid substitution mark is a code violation. It sets the alarm, and the mark decodes as 1.
- R6: The alarm output is high for exactly one cycle per violating mark. A cycle with no mark on either rail gives alarm 0 on the next cycle.
- R7: In dual-rail mode (dual_rail high), rx_data_or_p carries line_p and rx_alarm_or_n carries line_n with the R2 latency. In this mode hdb3_en has no effect and no violation is reported.
- R8: With alt_pol high in dual-rail mode, both rail outputs are inverted (active-low). In single-rail mode alt_pol has no effect.
- R9: While ais_req is high, the output register loads a mark on each edge. In single-rail mode this puts 1 on the data output. In dual-rail mode it puts a mark on both rail outputs in the selected polarity (1 normally, 0 with alt_pol).
- R10: In single-rail mode, alarm_test_n low forces rx_alarm_or_n to 1 from the next edge, and the data output is unaffected. In dual-rail mode the input does not alter the negative-rail output.
- R11: After reset the decoder takes the last mark as negative and the last valid substitution mark as positive. A first mark that is negative, with hdb3_en high, is therefore a valid substitution and decodes as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive clock |
| rst | input | 1 | Synchronous active-high reset |
| line_p | input | 1 | Positive-rail mark for the current bit slot |
| line_n | input | 1 | Negative-rail mark for the current bit slot |
| hdb3_en | input | 1 | Enables substitution removal (single-rail only) |
| dual_rail | input | 1 | 0 = single-rail unipolar output, 1 = dual-rail output |
| alt_pol | input | 1 | Active-low rail outputs in dual-rail mode |
| ais_req | input | 1 | Force all-marks toward the terminal |
| alarm_test_n | input | 1 | Active-low alarm test |
| rx_data_or_p | output | 1 | Unipolar data, or positive rail in dual-rail mode |
| rx_alarm_or_n | output | 1 | Violation alarm, or negative rail in dual-rail mode |

## Verification
Each result has its own due time. Decoded data and dual-rail data are due three edges after the edge that samples the rail bits. The violation alarm is due right after the sampling edge itself. The AIS, alarm-test and polarity overrides take effect at the first edge after they change. The bench drives one bit per cycle and samples both outputs at the falling edge after each step. It compares data samples against the input stream shifted by three slots, and alarm samples against the slot just applied. Full streams built by an independent HDB3 encoder and an AMI encoder check this alignment across all 256 byte patterns.

// File: rtl/hdb3rx_pkg.sv
package hdb3rx_pkg;

    // a substitution code spans the violating mark and the three slots before it
    localparam int unsigned SUB_SPAN = 4;

    typedef enum logic {
        POL_NEG = 1'b0,
        POL_POS = 1'b1
    } mark_pol_e;

    typedef struct packed {
        logic p;
        logic n;
    } rail_pair_t;

    typedef struct packed {
        logic      mark;
        mark_pol_e pol;
        logic      sub_hit;
        logic      bad;
    } line_event_t;

    localparam rail_pair_t RAIL_IDLE = '{p: 1'b0, n: 1'b0};
    localparam rail_pair_t RAIL_MARK = '{p: 1'b1, n: 1'b1};

    // Sort one incoming slot against the polarity history.
    function automatic line_event_t classify(
        input rail_pair_t r,
        input mark_pol_e  last_mark,
        input mark_pol_e  last_sub,
        input logic       hdb3
    );
        line_event_t ev;
        logic        repeat_pol;
        ev.mark     = r.p | r.n;
        ev.pol      = r.p ? POL_POS : POL_NEG;
        repeat_pol  = ev.mark && (ev.pol == last_mark);
        ev.sub_hit  = hdb3 && repeat_pol && (ev.pol != last_sub);
        ev.bad      = repeat_pol && !ev.sub_hit;
        return ev;
    endfunction

    function automatic rail_pair_t present(input rail_pair_t r, input logic invert);
        rail_pair_t o;
        o.p = r.p ^ invert;
        o.n = r.n ^ invert;
        return o;
    endfunction

endpackage

// File: rtl/hdb3rx_classifier.sv
module hdb3rx_classifier
    import hdb3rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  rail_pair_t  rail,
    input  logic        hdb3_en,
    output line_event_t ev
);

    mark_pol_e last_mark;
    mark_pol_e last_sub;

    always_comb begin
        ev = classify(rail, last_mark, last_sub, hdb3_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_mark <= POL_NEG;
            last_sub  <= POL_POS;
        end else begin
            if (ev.mark)    last_mark <= ev.pol;
            if (ev.sub_hit) last_sub  <= ev.pol;
        end
    end

endmodule

// File: rtl/hdb3rx_delay.sv
module hdb3rx_delay
    import hdb3rx_pkg::*;
#(
    parameter int unsigned DEPTH = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  rail_pair_t din,
    input  logic       zap,
    output rail_pair_t tail
);

    localparam int unsigned LAST = DEPTH - 1;

    rail_pair_t line [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst || zap) line[g] <= RAIL_IDLE;
                else            line[g] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst || zap) line[g] <= RAIL_IDLE;
                else            line[g] <= line[g-1];
            end
        end
    end

    // the oldest slot is also blanked when a substitution lands
    always_comb begin
        tail = zap ? RAIL_IDLE : line[LAST];
    end

endmodule

// File: rtl/hdb3rx_outstage.sv
module hdb3rx_outstage
    import hdb3rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rail_pair_t tail,
    input  logic       bad,
    input  logic       dual_rail,
    input  logic       alt_pol,
    input  logic       ais_req,
    input  logic       alarm_test_n,
    output logic       data_o,
    output logic       aux_o
);

    rail_pair_t pick;
    rail_pair_t shown;
    logic       data_nx;
    logic       aux_nx;

    always_comb begin
        pick  = ais_req ? RAIL_MARK : tail;
        shown = present(pick, alt_pol);
        if (dual_rail) begin
            data_nx = shown.p;
            aux_nx  = shown.n;
        end else begin
            data_nx = pick.p | pick.n;
            aux_nx  = !alarm_test_n || bad;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_o <= 1'b0;
            aux_o  <= 1'b0;
        end else begin
            data_o <= data_nx;
            aux_o  <= aux_nx;
        end
    end

endmodule

// File: rtl/hdb3_rx_decoder.sv
module hdb3_rx_decoder
    import hdb3rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic line_p,
    input  logic line_n,
    input  logic hdb3_en,
    input  logic dual_rail,
    input  logic alt_pol,
    input  logic ais_req,
    input  logic alarm_test_n,
    output logic rx_data_or_p,
    output logic rx_alarm_or_n
);

    localparam int unsigned LINE_DEPTH = SUB_SPAN - 1;

    rail_pair_t  rail_in;
    line_event_t ev;
    rail_pair_t  tail;
    logic        zap;
    logic        bad_single;

    assign rail_in    = '{p: line_p, n: line_n};
    assign zap        = ev.sub_hit && !dual_rail;
    assign bad_single = ev.bad && !dual_rail;

    hdb3rx_classifier u_cls (
        .clk     (clk),
        .rst     (rst),
        .rail    (rail_in),
        .hdb3_en (hdb3_en),
        .ev      (ev)
    );

    hdb3rx_delay #(.DEPTH(LINE_DEPTH)) u_dly (
        .clk  (clk),
        .rst  (rst),
        .din  (rail_in),
        .zap  (zap),
        .tail (tail)
    );

    hdb3rx_outstage u_out (
        .clk          (clk),
        .rst          (rst),
        .tail         (tail),
        .bad          (bad_single),
        .dual_rail    (dual_rail),
        .alt_pol      (alt_pol),
        .ais_req      (ais_req),
        .alarm_test_n (alarm_test_n),
        .data_o       (rx_data_or_p),
        .aux_o        (rx_alarm_or_n)
    );

endmodule

// File: rtl/hdb3_rx_decoder_chk.sv
module hdb3_rx_decoder_chk (
    input logic clk,
    input logic rst,
    input logic line_p,
    input logic line_n,
    input logic hdb3_en,
    input logic dual_rail,
    input logic alt_pol,
    input logic ais_req,
    input logic alarm_test_n,
    input logic rx_data_or_p,
    input logic rx_alarm_or_n
);

    p_ais_single_r9: assert property (@(posedge clk) disable iff (rst)
        (!dual_rail && ais_req) |=> rx_data_or_p);

    p_ais_dual_r9: assert property (@(posedge clk) disable iff (rst)
        (dual_rail && ais_req) |=>
            (rx_data_or_p == !$past(alt_pol) && rx_alarm_or_n == !$past(alt_pol)));

    p_alarm_test_r10: assert property (@(posedge clk) disable iff (rst)
        (!dual_rail && !alarm_test_n) |=> rx_alarm_or_n);

    p_bpv_repeat_r3: assert property (@(posedge clk) disable iff (rst)
        (!dual_rail && !hdb3_en && alarm_test_n && !$past(rst)
         && line_p && $past(line_p) && !$past(line_n)) |=> rx_alarm_or_n);

    p_quiet_slot_r6: assert property (@(posedge clk) disable iff (rst)
        (!dual_rail && alarm_test_n && !line_p && !line_n) |=> !rx_alarm_or_n);

endmodule

bind hdb3_rx_decoder hdb3_rx_decoder_chk u_chk (.*);

// File: tb/sim_hdb3_rx_decoder.sv
module sim_hdb3_rx_decoder;

    localparam int NB = 2048;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_p = 1'b0, line_n = 1'b0;
    logic hdb3_en = 1'b0, dual_rail = 1'b0, alt_pol = 1'b0;
    logic ais_req = 1'b0, alarm_test_n = 1'b1;
    logic rx_data_or_p, rx_alarm_or_n;

    always #2 clk = ~clk;

    hdb3_rx_decoder u0 (.*);

    int n_tests = 0;
    int n_fail  = 0;
    logic so_d, so_v;
    logic gd [16];
    logic gv [16];
    logic src [NB];
    logic hp [NB];
    logic hn [NB];
    logic ap [NB];
    logic an [NB];

    task automatic chk(input logic act, input logic exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic step(input logic p, input logic n);
        line_p = p;
        line_n = n;
        @(posedge clk);
        @(negedge clk);
        so_d = rx_data_or_p;
        so_v = rx_alarm_or_n;
    endtask

    task automatic cfg(input logic h, input logic d, input logic a, input logic s, input logic t);
        hdb3_en = h; dual_rail = d; alt_pol = a; ais_req = s; alarm_test_n = t;
    endtask

    task automatic do_reset();
        rst = 1'b1; line_p = 1'b0; line_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(rx_data_or_p, 1'b0, "R1 data in reset");
        chk(rx_alarm_or_n, 1'b0, "R1 alarm in reset");
        rst = 1'b0;
    endtask

    task automatic run_seq(input logic [15:0] ps, input logic [15:0] ns, input int len);
        for (int k = 0; k < len; k++) begin
            step(ps[k], ns[k]);
            gd[k] = so_d;
            gv[k] = so_v;
        end
    endtask

    task automatic run_stream(input logic use_hdb3);
        for (int i = 0; i < NB + 3; i++) begin
            if (i < NB) step(use_hdb3 ? hp[i] : ap[i], use_hdb3 ? hn[i] : an[i]);
            else        step(1'b0, 1'b0);
            if (i >= 3) chk(so_d, src[i-3], use_hdb3 ? "R4 hdb3 stream data" : "R2 ami stream data");
            chk(so_v, 1'b0, use_hdb3 ? "R4 hdb3 stream no alarm" : "R3 ami stream no alarm");
        end
    endtask

    // independent encoders producing the line streams
    initial begin
        int  i;
        logic lastp;
        int  pulses;
        for (int b = 0; b < NB; b++) src[b] = ((b / 8) >> (b % 8)) & 1;
        lastp = 1'b0;
        for (int b = 0; b < NB; b++) begin
            ap[b] = 1'b0; an[b] = 1'b0;
            if (src[b]) begin
                lastp = !lastp;
                ap[b] = lastp; an[b] = !lastp;
            end
        end
        lastp = 1'b0; pulses = 1; i = 0;
        for (int b = 0; b < NB; b++) begin hp[b] = 1'b0; hn[b] = 1'b0; end
        while (i < NB) begin
            if (i + 3 < NB && !src[i] && !src[i+1] && !src[i+2] && !src[i+3]) begin
                if (pulses % 2 == 0) begin
                    lastp = !lastp;
                    hp[i] = lastp; hn[i] = !lastp;
                end
                hp[i+3] = lastp; hn[i+3] = !lastp;
                pulses = 0;
                i += 4;
            end else begin
                if (src[i]) begin
                    lastp = !lastp;
                    hp[i] = lastp; hn[i] = !lastp;
                    pulses++;
                end
                i++;
            end
        end
    end

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        // AMI stream, substitution removal off
        cfg(0, 0, 0, 0, 1); do_reset(); run_stream(1'b0);
        // HDB3 stream
        cfg(1, 0, 0, 0, 1); do_reset(); run_stream(1'b1);

        // R3 / R6: repeated positive mark without HDB3
        cfg(0, 0, 0, 0, 1); do_reset();
        run_seq(16'b00011, 16'b0, 5);
        chk(gv[0], 1'b0, "R3 first mark no alarm");
        chk(gv[1], 1'b1, "R3 repeated mark alarm");
        chk(gv[2], 1'b0, "R6 alarm lasts one cycle");
        chk(gd[3], 1'b1, "R3 mark data 1");
        chk(gd[4], 1'b1, "R3 violating mark data 1");

        // R5: repeat matching last substitution polarity
        cfg(1, 0, 0, 0, 1); do_reset();
        run_seq(16'b0001001, 16'b0, 7);
        chk(gv[3], 1'b1, "R5 code violation alarm");
        chk(gv[4], 1'b0, "R6 code alarm one cycle");
        chk(gd[3], 1'b1, "R5 first mark data");
        chk(gd[6], 1'b1, "R5 violating mark decodes 1");

        // R4: B00V after a positive mark
        cfg(1, 0, 0, 0, 1); do_reset();
        run_seq(16'b00000001, 16'b00010010, 8);
        chk(gd[3], 1'b1, "R4 leading mark");
        for (int k = 4; k < 8; k++) chk(gd[k], 1'b0, "R4 substitution removed");
        for (int k = 0; k < 8; k++) chk(gv[k], 1'b0, "R4 no alarm");

        // R11: first negative mark after reset is a substitution
        cfg(1, 0, 0, 0, 1); do_reset();
        run_seq(16'b0, 16'b0001, 4);
        chk(gv[0], 1'b0, "R11 no alarm");
        chk(gd[3], 1'b0, "R11 decodes 0");

        // R7 / R8: dual rail passthrough, both polarities
        for (int a = 0; a < 2; a++) begin
            logic [15:0] ps = 16'b10110;
            logic [15:0] ns = 16'b11001;
            cfg(1, 1, a[0], 0, 1); do_reset();
            run_seq(ps, ns, 8);
            for (int k = 0; k < 5; k++) begin
                chk(gd[k+3], ps[k] ^ a[0], a[0] ? "R8 inverted p rail" : "R7 p rail");
                chk(gv[k+3], ns[k] ^ a[0], a[0] ? "R8 inverted n rail" : "R7 n rail");
            end
        end

        // R8: polarity ignored in single rail
        cfg(0, 0, 1, 0, 1); do_reset();
        run_seq(16'b001, 16'b010, 6);
        chk(gd[3], 1'b1, "R8 single p mark");
        chk(gd[4], 1'b1, "R8 single n mark");
        chk(gd[5], 1'b0, "R8 single space");

        // R9: AIS in each mode
        cfg(0, 0, 0, 1, 1); do_reset();
        run_seq(16'b0, 16'b0, 3);
        for (int k = 0; k < 3; k++) chk(gd[k], 1'b1, "R9 single AIS");
        for (int a = 0; a < 2; a++) begin
            cfg(0, 1, a[0], 1, 1); do_reset();
            run_seq(16'b0, 16'b0, 2);
            chk(gd[0], !a[0], "R9 dual AIS p");
            chk(gv[1], !a[0], "R9 dual AIS n");
        end

        // R10: alarm test
        cfg(0, 0, 0, 0, 0); do_reset();
        run_seq(16'b00001, 16'b00010, 5);
        for (int k = 0; k < 5; k++) chk(gv[k], 1'b1, "R10 alarm forced");
        chk(gd[3], 1'b1, "R10 data kept p");
        chk(gd[4], 1'b1, "R10 data kept n");
        cfg(0, 1, 0, 0, 0); do_reset();
        run_seq(16'b0, 16'b0001, 5);
        chk(gv[3], 1'b1, "R10 dual n rail mark");
        chk(gv[4], 1'b0, "R10 dual n rail not forced");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule